// File: doc/BRIEF.md
# Dual-Protocol Host Bus Slave

This block lets a byte-wide host processor reach an internal register port over one shared set of pins. A static strap, `mode_ack`, picks the bus protocol. When it is low, the host uses separate active-low read and write strobes, and the block answers with an active-high ready. When it is high, the host uses a read/write direction line together with an active-low data strobe, and the block answers with an active-low transfer acknowledge. A second static strap, `mode_mux`, picks the address scheme. Either a separate 8-bit address bus is used, or the address travels on the data lines and is captured while `addr_in[0]` acts as an address latch enable.

The host control pins are brought into the internal clock domain through a synchronizer. When the access condition rises, the block issues exactly one single-cycle request on the internal port. The request carries a registered address, a direction bit and write data. A fixed latency of `LAT` clocks later the access counts as complete, and read data taken from the register file at that point is presented to the host. The data bus and the handshake pin are described as a value plus an output enable. The enables drop combinationally as soon as the host releases chip select or the strobe, so the pads float without waiting on the clock.

Top module: `hbus_slave`

## Requirements
- R1: While reset is asserted and right after it, `data_oe`, `hs_oe` and `req_valid` are all 0.
- R2: With `mode_ack`=0, an access is `cs_n`=0 together with `strb_rd`=0 (read) or `strb_wr`=0 (write). Each access yields one request. The request has `req_write` equal to 1 for a write, the selected address on `req_addr` and, for a write, `data_in` on `req_wdata`.
- R3: With `mode_ack`=1, an access is `cs_n`=0 together with `strb_wr`=0, which acts as the data strobe. The direction comes from `strb_rd`: 1 means read and 0 means write. Each access yields one request with the same fields as in R2.
- R4: With `mode_mux`=0 the request address is `addr_in`. With `mode_mux`=1 it is the value on `data_in` captured while `addr_in[0]`=1. In that mode `addr_in[7:1]` has no effect on the address.
- R5: `req_valid` is a one-cycle pulse. Exactly one pulse occurs per access, however long the strobe is held. No pulse occurs while `cs_n`=1.
- R6: Completion comes exactly `LAT`=2 clocks after the request pulse. In the clock after `req_valid`, `hs_oe` is 0. In the clock after that, the handshake is driven as long as the access is still held.
- R7: For a completed read, `data_out` equals the `rd_data` value presented in the clock after the request. `data_oe` is 1 only while `cs_n`=0 and the read strobe is still held (`strb_rd`=0, or `strb_wr`=0 with `strb_rd`=1). It returns to 0 combinationally when the host releases either one.
- R8: With `mode_ack`=0, the ready pin is driven (`hs_oe`=1) with `hs_out`=1 after completion. It floats as soon as `cs_n` or the active strobe goes high.
- R9: With `mode_ack`=1, the acknowledge is driven low after completion. When the data strobe rises while `cs_n` stays 0, it is driven high and floats once the synchronized access has ended. A high `cs_n` floats it at once.
- R10: During a write access `data_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_ack | input | 1 | Static protocol strap: 1 = direction line/data strobe/acknowledge, 0 = read/write strobes/ready |
| mode_mux | input | 1 | Static address strap: 1 = address carried on data lines, 0 = separate address bus |
| cs_n | input | 1 | Active-low chip select |
| strb_wr | input | 1 | Write strobe (active low), or data strobe in acknowledge style |
| strb_rd | input | 1 | Read strobe (active low), or direction line (1 = read) in acknowledge style |
| addr_in | input | 8 | Address bus; bit 0 is the address latch enable in multiplexed mode |
| data_in | input | 8 | Data bus as seen by the pad input |
| data_out | output | 8 | Read data toward the pad |
| data_oe | output | 1 | Data pad output enable |
| hs_out | output | 1 | Handshake pad value (ready or acknowledge) |
| hs_oe | output | 1 | Handshake pad output enable |
| req_valid | output | 1 | Single-cycle internal request strobe |
| req_write | output | 1 | Request direction, 1 = write |
| req_addr | output | 8 | Request address |
| req_wdata | output | 8 | Request write data |
| rd_data | input | 8 | Register read data, sampled in the clock after the request |

## Verification
The bench holds each strobe long past completion. A design that detected level instead of edge would then issue repeated requests and break the one-request count. In multiplexed mode, garbage is put on the upper address pins, so a design that took its address from the wrong bus shows a wrong `req_addr`. The handshake is checked in the clocks just after the request, so a latency that is one clock too short or too long is caught. After the strobe is released and after chip select is released, the bench checks that the pads float without a clock edge, and that the acknowledge turns high rather than floating straight from low. Strobe assertion with chip select high must produce no request at all.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_WAIT,
    SQ_DONE
  } seq_state_t;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [W-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= stg_d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ack,
  input  logic          mode_mux,
  input  logic          cs_s,
  input  logic          wr_s,
  input  logic          rd_s,
  input  logic          ale_s,
  input  logic [DW-1:0] data_s,
  input  logic [AW-1:0] addr_in,
  output logic          act,
  output logic          is_wr,
  output logic [AW-1:0] cur_addr
);
  logic [AW-1:0] lat_q, lat_d;
  logic          lat_en;

  // protocol decode of the synchronized pins
  always_comb begin
    if (mode_ack) begin
      act   = !cs_s && !wr_s;
      is_wr = !rd_s;
    end else begin
      act   = !cs_s && (!rd_s || !wr_s);
      is_wr = !wr_s;
    end
  end

  // address latch, fed from a data pipeline aligned with the latch enable
  assign lat_en = mode_mux && ale_s;
  always_comb begin
    lat_d = lat_q;
    if (lat_en) lat_d = data_s[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  assign cur_addr = mode_mux ? lat_q : addr_in;
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 8,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          is_wr,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] rd_data,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rd_q
);
  localparam int CW = (LAT > 2) ? $clog2(LAT - 1) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(LAT - 2);

  seq_state_t    st_q, st_d;
  logic          act_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cap_en, rd_en;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rdat_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cap_en = 1'b0;
    rd_en  = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (act && !act_q) begin
        st_d   = SQ_REQ;
        cap_en = 1'b1;
      end
      SQ_REQ: begin
        st_d  = SQ_WAIT;
        cnt_d = CNT_LOAD;
      end
      SQ_WAIT: begin
        if (cnt_q == '0) begin
          st_d  = SQ_DONE;
          rd_en = !wr_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_DONE: if (!act) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      act_q <= act;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (cap_en) begin
      wr_q   <= is_wr;
      addr_q <= cur_addr;
      wd_q   <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdat_q <= '0;
    else if (rd_en) rdat_q <= rd_data;
  end

  assign req_valid = (st_q == SQ_REQ);
  assign done      = (st_q == SQ_DONE);
  assign req_write = wr_q;
  assign req_addr  = addr_q;
  assign req_wdata = wd_q;
  assign rd_q      = rdat_q;
endmodule

// File: rtl/hbus_drive.sv
module hbus_drive (
  input  logic mode_ack,
  input  logic cs_n,
  input  logic strb_wr,
  input  logic strb_rd,
  input  logic done,
  input  logic req_write,
  output logic data_oe,
  output logic hs_oe,
  output logic hs_out
);
  logic rd_pin_act;
  logic any_strb;

  // raw pins, so release needs no clock edge
  always_comb begin
    if (mode_ack) begin
      rd_pin_act = !strb_wr && strb_rd;
      any_strb   = !strb_wr;
    end else begin
      rd_pin_act = !strb_rd;
      any_strb   = !strb_rd || !strb_wr;
    end
  end

  assign data_oe = done && !req_write && !cs_n && rd_pin_act;
  assign hs_oe   = done && !cs_n && (mode_ack || any_strb);
  assign hs_out  = mode_ack ? strb_wr : 1'b1;
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LAT         = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ack,
  input  logic          mode_mux,
  input  logic          cs_n,
  input  logic          strb_wr,
  input  logic          strb_rd,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          hs_out,
  output logic          hs_oe,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] rd_data
);
  localparam int NCTL = 4;

  logic            rst_ni;
  logic [NCTL-1:0] ctl_s;
  logic [DW-1:0]   data_s;
  logic            act, is_wr, done;
  logic [AW-1:0]   cur_addr;

  hbus_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ni)
  );

  // order: {ale, rd, wr, cs}
  hbus_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_ctl (
    .clk(clk), .rst_n(rst_ni),
    .d({addr_in[0], strb_rd, strb_wr, cs_n}),
    .q(ctl_s)
  );

  hbus_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat (
    .clk(clk), .rst_n(rst_ni), .d(data_in), .q(data_s)
  );

  hbus_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_ni),
    .mode_ack(mode_ack), .mode_mux(mode_mux),
    .cs_s(ctl_s[0]), .wr_s(ctl_s[1]), .rd_s(ctl_s[2]), .ale_s(ctl_s[3]),
    .data_s(data_s), .addr_in(addr_in),
    .act(act), .is_wr(is_wr), .cur_addr(cur_addr)
  );

  hbus_seq #(.AW(AW), .DW(DW), .LAT(LAT)) u_seq (
    .clk(clk), .rst_n(rst_ni),
    .act(act), .is_wr(is_wr), .cur_addr(cur_addr),
    .wr_data(data_in), .rd_data(rd_data),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_q(data_out)
  );

  hbus_drive u_drv (
    .mode_ack(mode_ack), .cs_n(cs_n), .strb_wr(strb_wr), .strb_rd(strb_rd),
    .done(done), .req_write(req_write),
    .data_oe(data_oe), .hs_oe(hs_oe), .hs_out(hs_out)
  );
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_ack,
  input logic cs_n,
  input logic data_oe,
  input logic hs_out,
  input logic hs_oe,
  input logic req_valid,
  input logic req_write
);
  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R6
  hs_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !hs_oe);

  // R7
  rd_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !cs_n);

  // R8
  rdy_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_oe && !mode_ack) |-> hs_out);

  // R9
  ack_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_oe |-> !cs_n);

  // R10
  wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !req_write);
endmodule

bind hbus_slave hbus_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_ack(mode_ack), .cs_n(cs_n),
  .data_oe(data_oe), .hs_out(hs_out), .hs_oe(hs_oe),
  .req_valid(req_valid), .req_write(req_write)
);

// File: tb/hbus_slave_tb_top.sv
module hbus_slave_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       ack;
    logic       mux;
    logic       wr;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] junk;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b1, 8'h3C, 8'hC3, 8'h00},
    '{1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h00},
    '{1'b0, 1'b1, 1'b1, 8'h5A, 8'h81, 8'hFE},
    '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'hAA},
    '{1'b1, 1'b0, 1'b1, 8'h80, 8'h7E, 8'h00},
    '{1'b1, 1'b0, 1'b0, 8'h01, 8'h00, 8'h00},
    '{1'b1, 1'b1, 1'b1, 8'hA5, 8'h0F, 8'h54},
    '{1'b1, 1'b1, 1'b0, 8'h6E, 8'h00, 8'hFE}
  };

  logic       clk, rst_n;
  logic       mode_ack, mode_mux, cs_n, strb_wr, strb_rd;
  logic [7:0] addr_in, data_in, data_out, req_addr, req_wdata, rd_data;
  logic       data_oe, hs_out, hs_oe, req_valid, req_write;

  int n_chk, n_err, req_cnt;

  hbus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ack(mode_ack), .mode_mux(mode_mux),
    .cs_n(cs_n), .strb_wr(strb_wr), .strb_rd(strb_rd),
    .addr_in(addr_in), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .hs_out(hs_out), .hs_oe(hs_oe),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data)
  );

  // register file model: read data depends on the requested address
  assign rd_data = req_addr ^ 8'hA5;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) if (req_valid) req_cnt++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic bus_idle();
    cs_n = 1'b1; strb_wr = 1'b1; strb_rd = 1'b1;
  endtask

  task automatic run_vec(input vec_t v);
    int    base;
    bit    seen;
    string t;
    t = v.ack ? "R3" : "R2";
    mode_ack = v.ack; mode_mux = v.mux;
    @(negedge clk);
    cs_n = 1'b0;
    if (v.mux) begin
      data_in = v.addr;
      addr_in = {v.junk[7:1], 1'b1};
      repeat (4) @(negedge clk);
      addr_in = {v.junk[7:1], 1'b0};
    end else begin
      addr_in = v.addr;
    end
    @(negedge clk);
    data_in = v.wr ? v.data : ~v.addr;
    if (v.ack) strb_rd = !v.wr;
    #1 base = req_cnt;
    @(negedge clk);
    if (v.ack)     strb_wr = 1'b0;
    else if (v.wr) strb_wr = 1'b0;
    else           strb_rd = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (req_valid) begin seen = 1'b1; break; end
    end
    chk(seen, {t, " request issued"}, 32'(seen), 1);
    chk(req_write == v.wr, {t, " request direction"}, 32'(req_write), 32'(v.wr));
    chk(req_addr == v.addr, v.mux ? "R4 muxed address" : "R4 separate address", 32'(req_addr), 32'(v.addr));
    if (v.wr) chk(req_wdata == v.data, {t, " write data"}, 32'(req_wdata), 32'(v.data));
    @(negedge clk);
    chk(hs_oe == 1'b0, "R6 no handshake one clock after request", 32'(hs_oe), 0);
    @(negedge clk);
    chk(hs_oe == 1'b1, "R6 handshake two clocks after request", 32'(hs_oe), 1);
    chk(hs_out == !v.ack, v.ack ? "R9 acknowledge low" : "R8 ready high", 32'(hs_out), 32'(!v.ack));
    if (v.wr) begin
      chk(data_oe == 1'b0, "R10 no data drive on write", 32'(data_oe), 0);
    end else begin
      chk(data_oe == 1'b1, "R7 read data driven", 32'(data_oe), 1);
      chk(data_out == (v.addr ^ 8'hA5), "R7 read data value", 32'(data_out), 32'(v.addr ^ 8'hA5));
    end
    repeat (5) @(negedge clk);
    #1 chk(req_cnt == base + 1, "R5 single request on long strobe", 32'(req_cnt - base), 1);
    @(negedge clk);
    if (v.ack) strb_wr = 1'b1;
    else begin strb_wr = 1'b1; strb_rd = 1'b1; end
    #1;
    chk(data_oe == 1'b0, "R7 data released with strobe", 32'(data_oe), 0);
    if (v.ack) begin
      chk(hs_oe && hs_out, "R9 acknowledge driven high after strobe release", 32'({hs_oe, hs_out}), 3);
    end else begin
      chk(hs_oe == 1'b0, "R8 ready floats on strobe release", 32'(hs_oe), 0);
    end
    repeat (6) @(negedge clk);
    chk(hs_oe == 1'b0, "R9 handshake floats after access ends", 32'(hs_oe), 0);
    bus_idle();
    #1 chk(req_cnt == base + 1, "R5 one request per access", 32'(req_cnt - base), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int base;
    n_chk = 0; n_err = 0; req_cnt = 0;
    rst_n = 1'b0; mode_ack = 1'b0; mode_mux = 1'b0;
    bus_idle(); addr_in = '0; data_in = '0;
    repeat (3) @(negedge clk);
    chk(!data_oe && !hs_oe && !req_valid, "R1 outputs idle in reset", 32'({data_oe, hs_oe, req_valid}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!data_oe && !hs_oe && !req_valid, "R1 outputs idle after reset", 32'({data_oe, hs_oe, req_valid}), 0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // strobe without chip select: no request
    mode_ack = 1'b0; mode_mux = 1'b0;
    #1 base = req_cnt;
    @(negedge clk); strb_rd = 1'b0;
    repeat (10) @(negedge clk);
    #1 chk(req_cnt == base, "R5 no request without chip select", 32'(req_cnt - base), 0);
    chk(hs_oe == 1'b0 && data_oe == 1'b0, "R5 no drive without chip select", 32'({hs_oe, data_oe}), 0);
    bus_idle();
    mode_ack = 1'b1;
    @(negedge clk); strb_wr = 1'b0;
    repeat (10) @(negedge clk);
    #1 chk(req_cnt == base, "R5 no request without chip select, data strobe", 32'(req_cnt - base), 0);
    bus_idle();

    // acknowledge style: chip select released first floats at once
    repeat (4) @(negedge clk);
    addr_in = 8'h33;
    cs_n = 1'b0; strb_rd = 1'b1;
    @(negedge clk); strb_wr = 1'b0;
    repeat (8) @(negedge clk);
    chk(hs_oe && !hs_out, "R9 acknowledge low before chip select release", 32'({hs_oe, hs_out}), 2);
    chk(data_oe && data_out == (8'h33 ^ 8'hA5), "R7 read data before chip select release", 32'(data_out), 32'(8'h33 ^ 8'hA5));
    cs_n = 1'b1;
    #1;
    chk(hs_oe == 1'b0, "R9 acknowledge floats on chip select release", 32'(hs_oe), 0);
    chk(data_oe == 1'b0, "R7 data floats on chip select release", 32'(data_oe), 0);
    bus_idle();
    repeat (8) @(negedge clk);

    summary();
    $finish;
  end
endmodule